// File: doc/BRIEF.md
# Serial Programming Target Interface

This block is the device-side end of a four-byte serial programming link. A programmer drives a serial clock and a data line. The block samples the incoming line on rising clock edges and updates its outgoing line on falling edges, both through synchronisers in the system clock domain. Every 32 received bits form one instruction. After the programmer has unlocked the port, the block decodes the instruction and acts on a small built-in model of a word-organised program store and a byte-organised data store.

Writes and whole-array erases are timed by a busy counter whose lengths are parameters given in system clock cycles. While a byte write is still running, a read of that location returns fixed polling markers instead of the stored value, so the programmer can poll for completion. The programming reset input is active low. While it is high, the port is idle and its framing counters are cleared, so every session starts on a byte boundary.

Top module: `sprog_target`

## Requirements
- R1: `mosi` is captured on rising `sck` edges and `miso` changes only after falling `sck` edges. Both lines carry bytes most significant bit first, and while the first byte of an instruction is being received `miso` sends 0x00.
- R2: Only the unlock instruction (first byte 0xAC, second byte 0x53, last two bytes ignored) is acted on until one has been accepted with `prog_rst_n` low. Taking `prog_rst_n` high locks the port again.
- R3: While the second and third bytes are being received, `miso` echoes the byte received just before. During the third byte of the unlock instruction this is 0x53. During the fourth byte `miso` sends the read result of a read instruction, or else echoes the third byte.
- R4: Program-store writes use a first byte of 0x40 and reads use 0x20, with first-byte bit 3 choosing the high (1) or low (0) byte of the word. The word address is the low FLASH_AW bits of {second byte[3:0], third byte}, and the data is the fourth byte.
- R5: Data-store writes use first byte 0xC0 and reads use 0xA0. The address is the low EE_AW bits of {second byte[0], third byte}, and the data is the fourth byte.
- R6: First byte 0xAC with second-byte bits [7:5] = 100 sets every location of both stores to 0xFF, returns both lock bits to unprogrammed, and keeps the port busy for ERASE_CYC cycles. Reset also leaves every location at 0xFF.
- R7: First byte 0xAC with second-byte bits [7:5] = 111 programs lock bit 1 when second-byte bit 1 is 0 and lock bit 2 when bit 2 is 0. A programmed lock bit is never returned to unprogrammed by this instruction.
- R8: First byte 0x30 reads signature byte a (a = third-byte bits [1:0]) as SIGNATURE[8a+7:8a]. It reads 0x00 when both lock bits are programmed.
- R9: For PROG_CYC cycles after a program-store write is accepted, reading that byte returns 0x7F. After that the written value is returned.
- R10: After a data-store write is accepted, reading that address returns 0x80 for the first EE_ERASE_CYC cycles and 0x7F for the rest of PROG_CYC cycles. After that the written value is returned.
- R11: Any write, erase or lock instruction that completes while the port is busy is ignored, and the stores and the lock bits are left unchanged.
- R12: Taking `prog_rst_n` high clears the bit and byte counters and sets `miso` to 0, so bits sent before it do not shift the framing of the next session.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the serial lines are oversampled with it |
| rst | input | 1 | Synchronous active-high reset |
| prog_rst_n | input | 1 | Programming reset, active low; low enables the port |
| sck | input | 1 | Serial clock from the programmer |
| mosi | input | 1 | Serial data from the programmer |
| miso | output | 1 | Serial data to the programmer |

## Verification
The hardest situation to reach from the ports is a read that lands in a chosen phase of a data-store write. The address must still be in its erase phase for the 0x80 marker, in its programming phase for 0x7F, and past the end of the write for the true value. The bench sends instructions back to back at a fixed serial rate, so the cycle at which each read result is loaded into the output shifter sits at a known offset from the preceding write. The phase parameters are chosen so that the first and second reads after a write fall in the two busy phases with a margin of about 80 cycles. The same fixed spacing places one write inside a busy window, which shows that it is dropped.

// File: rtl/sprog_pkg.sv
package sprog_pkg;

    localparam logic [7:0] POLL_BUSY  = 8'h7F;
    localparam logic [7:0] POLL_ERASE = 8'h80;
    localparam logic [7:0] ERASED     = 8'hFF;

    typedef enum logic [3:0] {
        CMD_NOP, CMD_UNLOCK, CMD_ERASE, CMD_LOCK,
        CMD_FRD, CMD_FWR, CMD_ERD, CMD_EWR, CMD_SIG
    } cmd_e;

    typedef struct packed {
        cmd_e        cmd;
        logic        hi;
        logic [11:0] faddr;
        logic [8:0]  eaddr;
        logic [1:0]  saddr;
        logic [1:0]  lock_w;   // [1] lock bit 2, [0] lock bit 1
        logic [7:0]  data;
    } instr_t;

    function automatic cmd_e decode(input logic [7:0] b0, input logic [7:0] b1);
        cmd_e c;
        c = CMD_NOP;
        if (b0 == 8'hAC) begin
            if (b1 == 8'h53)              c = CMD_UNLOCK;
            else if (b1[7:5] == 3'b100)   c = CMD_ERASE;
            else if (b1[7:5] == 3'b111)   c = CMD_LOCK;
        end
        else if ({b0[7:4], b0[2:0]} == 7'b0010_000) c = CMD_FRD;
        else if ({b0[7:4], b0[2:0]} == 7'b0100_000) c = CMD_FWR;
        else if (b0 == 8'hA0) c = CMD_ERD;
        else if (b0 == 8'hC0) c = CMD_EWR;
        else if (b0 == 8'h30) c = CMD_SIG;
        return c;
    endfunction

    function automatic instr_t split(input logic [31:0] w);
        instr_t r;
        r.cmd    = decode(w[31:24], w[23:16]);
        r.hi     = w[27];
        r.faddr  = {w[19:16], w[15:8]};
        r.eaddr  = {w[16], w[15:8]};
        r.saddr  = w[9:8];
        r.lock_w = w[18:17];
        r.data   = w[7:0];
        return r;
    endfunction

endpackage

// File: rtl/sprog_sync.sv
module sprog_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    logic [WIDTH-1:0] st [STAGES];
    logic [WIDTH-1:0] q_d;

    always_ff @(posedge clk) begin
        if (rst) st[0] <= '0;
        else     st[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) st[s] <= '0;
            else     st[s] <= st[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q_d <= '0;
        else     q_d <= q;
    end

    assign q    = st[STAGES-1];
    assign rise = q & ~q_d;
    assign fall = ~q & q_d;
endmodule

// File: rtl/sprog_frame.sv
module sprog_frame (
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        rise,
    input  logic        fall,
    input  logic        din,
    input  logic [7:0]  tx_byte,
    output logic [31:0] sr,
    output logic [1:0]  byte_idx,
    output logic        word_valid,
    output logic        miso
);
    logic [4:0] bitcnt;
    logic [7:0] txsr;

    always_ff @(posedge clk) begin
        if (clr) begin
            bitcnt     <= '0;
            sr         <= '0;
            txsr       <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            if (rise) begin
                sr     <= {sr[30:0], din};
                bitcnt <= bitcnt + 5'd1;
                if (bitcnt == 5'd31) word_valid <= 1'b1;
            end else if (fall) begin
                if (bitcnt[2:0] == 3'd0) txsr <= tx_byte;
                else                     txsr <= {txsr[6:0], 1'b0};
            end
        end
    end

    assign byte_idx = bitcnt[4:3];
    assign miso     = txsr[7];

    assert_miso_on_fall_R1: assert property (@(posedge clk) disable iff (rst)
        !$stable(miso) |-> ($past(fall) || $past(clr)));

    assert_word_on_rise_R12: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> $past(rise));
endmodule

// File: rtl/sprog_nvm.sv
module sprog_nvm #(
    parameter int FLASH_AW     = 4,
    parameter int EE_AW        = 4,
    parameter int PROG_CYC     = 1000,
    parameter int EE_ERASE_CYC = 500,
    parameter int ERASE_CYC    = 2000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_flash,
    input  logic                wr_ee,
    input  logic                erase,
    input  logic                wr_hi,
    input  logic [FLASH_AW-1:0] wr_faddr,
    input  logic [EE_AW-1:0]    wr_eaddr,
    input  logic [7:0]          wdata,
    input  logic                rd_hi,
    input  logic [FLASH_AW-1:0] rd_faddr,
    input  logic [EE_AW-1:0]    rd_eaddr,
    output logic [7:0]          flash_rd,
    output logic [7:0]          ee_rd,
    output logic                busy
);
    import sprog_pkg::*;

    localparam int FDEPTH   = 2 ** (FLASH_AW + 1);
    localparam int EDEPTH   = 2 ** EE_AW;
    localparam int MAXC     = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int CW       = $clog2(MAXC + 1);
    localparam int EE_SPLIT = PROG_CYC - EE_ERASE_CYC;

    typedef enum logic [1:0] {P_IDLE, P_FLASH, P_EE, P_ERASE} pend_e;

    logic [7:0]        flash_mem [FDEPTH];
    logic [7:0]        ee_mem    [EDEPTH];
    logic [CW-1:0]     cnt;
    pend_e             kind;
    logic [FLASH_AW:0] p_fidx;
    logic [EE_AW-1:0]  p_eidx;
    logic [7:0]        p_data;

    assign busy = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            kind   <= P_IDLE;
            p_fidx <= '0;
            p_eidx <= '0;
            p_data <= '0;
            for (int i = 0; i < FDEPTH; i++) flash_mem[i] <= ERASED;
            for (int i = 0; i < EDEPTH; i++) ee_mem[i]    <= ERASED;
        end else if (!busy && erase) begin
            for (int i = 0; i < FDEPTH; i++) flash_mem[i] <= ERASED;
            for (int i = 0; i < EDEPTH; i++) ee_mem[i]    <= ERASED;
            cnt  <= CW'(ERASE_CYC);
            kind <= P_ERASE;
        end else if (!busy && wr_flash) begin
            cnt    <= CW'(PROG_CYC);
            kind   <= P_FLASH;
            p_fidx <= {wr_faddr, wr_hi};
            p_data <= wdata;
        end else if (!busy && wr_ee) begin
            cnt    <= CW'(PROG_CYC);
            kind   <= P_EE;
            p_eidx <= wr_eaddr;
            p_data <= wdata;
        end else if (busy) begin
            cnt <= cnt - 1'b1;
            if (cnt == CW'(1)) begin
                if (kind == P_FLASH) flash_mem[p_fidx] <= p_data;
                if (kind == P_EE)    ee_mem[p_eidx]    <= p_data;
                kind <= P_IDLE;
            end
        end
    end

    always_comb begin
        if (kind == P_FLASH && p_fidx == {rd_faddr, rd_hi})
            flash_rd = POLL_BUSY;
        else
            flash_rd = flash_mem[{rd_faddr, rd_hi}];
        if (kind == P_EE && p_eidx == rd_eaddr)
            ee_rd = (cnt > CW'(EE_SPLIT)) ? POLL_ERASE : POLL_BUSY;
        else
            ee_rd = ee_mem[rd_eaddr];
    end

    assert_busy_drop_R11: assert property (@(posedge clk) disable iff (rst)
        (busy && (wr_flash || wr_ee || erase)) |=> (cnt == $past(cnt) - 1'b1));

    assert_erase_fill_R6: assert property (@(posedge clk) disable iff (rst)
        (erase && !busy) |=> (flash_mem[0] == ERASED && ee_mem[0] == ERASED));
endmodule

// File: rtl/sprog_target.sv
module sprog_target #(
    parameter int          FLASH_AW     = 4,
    parameter int          EE_AW        = 4,
    parameter int          PROG_CYC     = 1000,
    parameter int          EE_ERASE_CYC = 500,
    parameter int          ERASE_CYC    = 2000,
    parameter logic [31:0] SIGNATURE    = 32'h0006931E
) (
    input  logic clk,
    input  logic rst,
    input  logic prog_rst_n,
    input  logic sck,
    input  logic mosi,
    output logic miso
);
    import sprog_pkg::*;

    logic [2:0]  s_q, s_rise, s_fall;
    logic        prog_hi, clr;
    logic [31:0] fr_sr;
    logic [1:0]  fr_idx;
    logic        fr_valid;
    logic [7:0]  tx_byte, rd_byte, flash_rd, ee_rd;
    logic        en, busy;
    logic [1:0]  lock_n;   // 1 = unprogrammed
    instr_t      ins, rdi;
    logic        do_fwr, do_ewr, do_erase, do_lock;

    sprog_sync #(.WIDTH(3), .STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .din({prog_rst_n, mosi, sck}),
        .q(s_q), .rise(s_rise), .fall(s_fall)
    );

    assign prog_hi = s_q[2];
    assign clr     = rst | prog_hi;

    sprog_frame u_frame (
        .clk(clk), .rst(rst), .clr(clr), .rise(s_rise[0]), .fall(s_fall[0]),
        .din(s_q[1]), .tx_byte(tx_byte), .sr(fr_sr), .byte_idx(fr_idx),
        .word_valid(fr_valid), .miso(miso)
    );

    assign ins = split(fr_sr);
    assign rdi = split({fr_sr[23:0], 8'h00});

    assign do_fwr   = fr_valid && en && ins.cmd == CMD_FWR;
    assign do_ewr   = fr_valid && en && ins.cmd == CMD_EWR;
    assign do_erase = fr_valid && en && ins.cmd == CMD_ERASE;
    assign do_lock  = fr_valid && en && ins.cmd == CMD_LOCK && !busy;

    always_ff @(posedge clk) begin
        if (clr) en <= 1'b0;
        else if (fr_valid && ins.cmd == CMD_UNLOCK) en <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) lock_n <= 2'b11;
        else if (do_erase && !busy) lock_n <= 2'b11;
        else if (do_lock) lock_n <= lock_n & ins.lock_w;
    end

    sprog_nvm #(
        .FLASH_AW(FLASH_AW), .EE_AW(EE_AW), .PROG_CYC(PROG_CYC),
        .EE_ERASE_CYC(EE_ERASE_CYC), .ERASE_CYC(ERASE_CYC)
    ) u_nvm (
        .clk(clk), .rst(rst), .wr_flash(do_fwr), .wr_ee(do_ewr), .erase(do_erase),
        .wr_hi(ins.hi), .wr_faddr(ins.faddr[FLASH_AW-1:0]),
        .wr_eaddr(ins.eaddr[EE_AW-1:0]), .wdata(ins.data),
        .rd_hi(rdi.hi), .rd_faddr(rdi.faddr[FLASH_AW-1:0]),
        .rd_eaddr(rdi.eaddr[EE_AW-1:0]),
        .flash_rd(flash_rd), .ee_rd(ee_rd), .busy(busy)
    );

    always_comb begin
        rd_byte = fr_sr[7:0];
        if (en) begin
            case (rdi.cmd)
                CMD_FRD: rd_byte = flash_rd;
                CMD_ERD: rd_byte = ee_rd;
                CMD_SIG: rd_byte = (lock_n == 2'b00) ? 8'h00
                                                     : SIGNATURE[8*rdi.saddr +: 8];
                default: rd_byte = fr_sr[7:0];
            endcase
        end
        case (fr_idx)
            2'd0:    tx_byte = 8'h00;
            2'd3:    tx_byte = rd_byte;
            default: tx_byte = fr_sr[7:0];
        endcase
    end

    assert_relock_R2: assert property (@(posedge clk) disable iff (rst)
        (prog_hi && en) |=> !en);

    assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (!do_erase && $past(!rst)) |=> ((lock_n & ~$past(lock_n)) == 2'b00));
endmodule

// File: tb/sprog_target_tb.sv
module sprog_target_tb;
    localparam int H = 8;

    logic clk = 1'b0;
    logic rst, prog_rst_n, sck, mosi;
    logic miso;
    int   vectors = 0;
    int   miscompares = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    sprog_target u_dut (
        .clk(clk), .rst(rst), .prog_rst_n(prog_rst_n),
        .sck(sck), .mosi(mosi), .miso(miso)
    );

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic xbits(input int n, input logic [31:0] w, output logic [31:0] r);
        r = '0;
        for (int i = n - 1; i >= 0; i--) begin
            mosi = w[i];
            waitc(H);
            r[i] = miso;
            sck = 1'b1;
            waitc(H);
            sck = 1'b0;
        end
        waitc(H);
    endtask

    task automatic xfer(input logic [31:0] w, output logic [31:0] r);
        xbits(32, w, r);
    endtask

    task automatic rd(input logic [31:0] w, output logic [7:0] d);
        logic [31:0] r;
        xfer(w, r);
        d = r[7:0];
    endtask

    function automatic logic [7:0] fdat(input int a, input int h);
        return 8'(a * 37 + h * 91 + 5);
    endfunction

    function automatic logic [7:0] edat(input int a);
        return 8'(a * 29 + 11);
    endfunction

    initial begin
        logic [31:0] r;
        logic [7:0]  d;
        rst = 1'b1; prog_rst_n = 1'b0; sck = 1'b0; mosi = 1'b0;
        waitc(5);
        rst = 1'b0;
        waitc(5);
        chk("R1 reset miso", {7'd0, miso}, 8'h00);

        // R2: write before unlock is ignored
        xfer(32'h40_00_03_5A, r);
        xfer(32'hAC_53_00_00, r);
        chk("R1 first byte zero", r[31:24], 8'h00);
        chk("R3 echo byte1", r[23:16], 8'hAC);
        chk("R3 echo 0x53", r[15:8], 8'h53);
        rd(32'h20_00_03_00, d);
        chk("R2 locked write ignored", d, 8'hFF);
        xfer(32'h20_00_03_00, r);
        chk("R3 non-read echo in byte2", r[23:16], 8'h20);

        // R4, R9: program store sweep with polling
        for (int a = 0; a < 16; a++) begin
            for (int h = 0; h < 2; h++) begin
                xfer({4'h4, h[0], 3'b000, 8'h00, 8'(a), fdat(a, h)}, r);
                rd({4'h2, h[0], 3'b000, 8'h00, 8'(a), 8'h00}, d);
                chk("R9 program poll 0x7F", d, 8'h7F);
                waitc(60);
            end
        end
        for (int a = 0; a < 16; a++) begin
            for (int h = 0; h < 2; h++) begin
                rd({4'h2, h[0], 3'b000, 8'h00, 8'(a), 8'h00}, d);
                chk("R4 program readback", d, fdat(a, h));
            end
        end
        // R4: upper address bits beyond FLASH_AW wrap
        rd({8'h28, 8'h0A, 8'h13, 8'h00}, d);
        chk("R4 address wrap", d, fdat(3, 1));

        // R5, R10: data store sweep with two-phase polling
        for (int a = 0; a < 16; a++) begin
            xfer({8'hC0, 8'h00, 8'(a), edat(a)}, r);
            rd({8'hA0, 8'h00, 8'(a), 8'h00}, d);
            chk("R10 erase phase 0x80", d, 8'h80);
            rd({8'hA0, 8'h00, 8'(a), 8'h00}, d);
            chk("R10 write phase 0x7F", d, 8'h7F);
            waitc(60);
        end
        for (int a = 0; a < 16; a++) begin
            rd({8'hA0, 8'h00, 8'(a), 8'h00}, d);
            chk("R5 data readback", d, edat(a));
        end

        // R11: writes during busy dropped
        xfer({8'hC0, 8'h00, 8'd2, 8'h33}, r);
        xfer({8'hC0, 8'h00, 8'd5, 8'h44}, r);
        waitc(1100);
        rd({8'hA0, 8'h00, 8'd5, 8'h00}, d);
        chk("R11 data write dropped", d, edat(5));
        rd({8'hA0, 8'h00, 8'd2, 8'h00}, d);
        chk("R5 data rewrite", d, 8'h33);
        xfer({8'h40, 8'h00, 8'd0, 8'hC3}, r);
        xfer({8'h48, 8'h00, 8'd1, 8'h3C}, r);
        waitc(1100);
        rd({8'h28, 8'h00, 8'd1, 8'h00}, d);
        chk("R11 program write dropped", d, fdat(1, 1));
        rd({8'h20, 8'h00, 8'd0, 8'h00}, d);
        chk("R4 program rewrite", d, 8'hC3);

        // R8, R7: signature and lock bits
        for (int a = 0; a < 4; a++) begin
            rd({8'h30, 8'h00, 8'(a), 8'h00}, d);
            chk("R8 signature", d, 8'(32'h0006931E >> (8 * a)));
        end
        xfer(32'hAC_FD_00_00, r);
        rd(32'h30_00_01_00, d);
        chk("R7 one lock bit keeps signature", d, 8'h93);
        xfer(32'hAC_FB_00_00, r);
        rd(32'h30_00_00_00, d);
        chk("R8 both locks hide signature", d, 8'h00);
        xfer(32'hAC_FF_00_00, r);
        rd(32'h30_00_01_00, d);
        chk("R7 lock not undone", d, 8'h00);

        // R6: chip erase
        xfer(32'hAC_80_00_00, r);
        xfer({8'hC0, 8'h00, 8'd7, 8'h21}, r);
        waitc(2100);
        rd(32'h30_00_00_00, d);
        chk("R6 erase clears locks", d, 8'h1E);
        rd({8'h20, 8'h00, 8'd0, 8'h00}, d);
        chk("R6 program erased", d, 8'hFF);
        rd({8'hA0, 8'h00, 8'd2, 8'h00}, d);
        chk("R6 data erased", d, 8'hFF);
        rd({8'hA0, 8'h00, 8'd7, 8'h00}, d);
        chk("R11 write during erase dropped", d, 8'hFF);

        // R12, R2: partial bits then programming reset
        xbits(5, 32'h0000_0015, r);
        prog_rst_n = 1'b1;
        waitc(20);
        chk("R12 miso idle", {7'd0, miso}, 8'h00);
        prog_rst_n = 1'b0;
        waitc(20);
        xfer({8'hC0, 8'h00, 8'd1, 8'h99}, r);
        xfer(32'hAC_53_00_00, r);
        chk("R12 realigned echo", r[15:8], 8'h53);
        rd({8'hA0, 8'h00, 8'd1, 8'h00}, d);
        chk("R2 relocked write ignored", d, 8'hFF);
        xfer({8'hC0, 8'h00, 8'd1, 8'h99}, r);
        waitc(1100);
        rd({8'hA0, 8'h00, 8'd1, 8'h00}, d);
        chk("R5 write after new session", d, 8'h99);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule